// File: doc/BRIEF.md
# Paired-Register 64-Bit Logical Right Shift Unit

This execute-stage unit carries out a single instruction: a logical right shift of a 64-bit value held across two 32-bit registers. The high half comes from the accumulator and the low half from the product register. A 16-bit instruction word is decoded to confirm the operation and to extract a 4-bit shift field. The field selects an immediate shift of 1 to 16 places. Zeros enter at the top of the pair. The last bit pushed out at the bottom becomes the carry, and every other bit that leaves is dropped.

One clock after a valid, matching instruction word is presented, the unit drives both new register values with their write enables. It also drives the negative, zero and carry flags with a flag-write strobe. The instruction cannot be repeated. If a repeat prefix has left a non-zero count, the unit requests that the count be cleared, so the operation runs exactly once. Words that do not match leave every output as it was. The surrounding pipeline performs the register and status writes, and it owns all other status bits.

Top module: `pair_shift_unit`

## Requirements
- R1: The instruction is recognised when `instr_valid` is 1 and `instr_word[15:4]` equals binary 0101_0110_1001 (0x569). One cycle later `acc_we`, `p_we` and `flag_we` are 1 for exactly one cycle.
- R2: The shift amount is `instr_word[3:0]` plus one. A field of 0 shifts by 1 and a field of 15 shifts by 16.
- R3: The operand is `{acc_in, p_in}`, with `acc_in` as bits 63..32. The result is the operand shifted right with zero fill, returned as `{acc_out, p_out}`.
- R4: `flag_c` equals bit (amount-1) of the original operand, which is the last bit shifted out.
- R5: `flag_n` equals bit 31 of the new `acc_out`. Because the shift is always at least one place, this bit is always 0.
- R6: `flag_z` is 1 exactly when the whole 64-bit result is zero.
- R7: A word that does not match, or any word with `instr_valid` low, leaves all write enables at 0 the next cycle. In that case `acc_out`, `p_out`, `flag_n`, `flag_z`, `flag_c` and `rpt_count_out` keep their previous values.
- R8: When the instruction executes with `rpt_count_in` non-zero, `rpt_we` is 1 one cycle later and `rpt_count_out` is 0. When it executes with a zero count, `rpt_we` stays 0. Each accepted word gives one result cycle only.
- R9: While `rst` is high at a clock edge, all outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 16 | Instruction word: match tag in [15:4], shift field in [3:0] |
| acc_in | input | 32 | Current accumulator (upper half of operand) |
| p_in | input | 32 | Current product register (lower half of operand) |
| rpt_count_in | input | 16 | Current repeat-prefix count |
| acc_out | output | 32 | New accumulator value |
| p_out | output | 32 | New product register value |
| acc_we | output | 1 | Accumulator write enable |
| p_we | output | 1 | Product register write enable |
| flag_n | output | 1 | Negative flag value |
| flag_z | output | 1 | Zero flag value |
| flag_c | output | 1 | Carry flag value |
| flag_we | output | 1 | Write strobe for N, Z and C only |
| rpt_count_out | output | 16 | New repeat count (always 0 when written) |
| rpt_we | output | 1 | Repeat count write enable |

## Verification
The bench presents every one of the 65536 instruction words. This catches a decoder that compares too few or too many tag bits, because such a decoder would execute on a neighbouring opcode or refuse the real one. Each of the 16 shift fields is run against single-bit, all-ones and scrambled operands. A design with an off-by-one in the amount would move the result by one place and take its carry from the wrong bit. Bits are placed exactly at the half boundary and at the carry position, so a failure to carry across from the accumulator into the product register, or sign filling instead of zero filling, shows at once. Shifts that leave only zeros, or only the carry bit, exercise Z. Repeat counts of zero and non-zero exercise the clear request. Idle cycles in between confirm that nothing moves without a matching word.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int REG_W_DEF   = 32;
    localparam int WORD_W_DEF  = 16;
    localparam int FIELD_W_DEF = 4;
    localparam int RPT_W_DEF   = 16;
    localparam int TAG_W_DEF   = WORD_W_DEF - FIELD_W_DEF;

    // Upper bits of the instruction word that identify the operation.
    localparam logic [TAG_W_DEF-1:0] OPC_TAG = 12'b0101_0110_1001;

    // Status bits written by the operation.
    typedef struct packed {
        logic n;
        logic z;
        logic c;
    } nzc_t;

    // Write enables produced for one executed instruction.
    typedef struct packed {
        logic acc;
        logic p;
        logic flags;
        logic rpt;
    } wen_t;

    localparam wen_t WEN_NONE = '{acc: 1'b0, p: 1'b0, flags: 1'b0, rpt: 1'b0};
    localparam nzc_t NZC_CLR  = '{n: 1'b0, z: 1'b0, c: 1'b0};

    // Non-zero test kept as a function so callers read as intent.
    function automatic logic count_pending(input logic [RPT_W_DEF-1:0] cnt);
        return cnt != '0;
    endfunction

endpackage

// File: rtl/psr_decode.sv
module psr_decode #(
    parameter int WORD_W  = psr_pkg::WORD_W_DEF,
    parameter int FIELD_W = psr_pkg::FIELD_W_DEF,
    parameter int TAG_W   = WORD_W - FIELD_W,
    parameter logic [TAG_W-1:0] TAG = TAG_W'(psr_pkg::OPC_TAG)
) (
    input  logic               valid,
    input  logic [WORD_W-1:0]  word,
    output logic               hit,
    output logic [FIELD_W-1:0] field
);

    logic [TAG_W-1:0] upper;

    always_comb begin
        upper = word[WORD_W-1:FIELD_W];
        field = word[FIELD_W-1:0];
        hit   = valid && (upper == TAG);
    end

endmodule

// File: rtl/psr_shift.sv
module psr_shift #(
    parameter int PAIR_W  = 2 * psr_pkg::REG_W_DEF,
    parameter int FIELD_W = psr_pkg::FIELD_W_DEF
) (
    input  logic [PAIR_W-1:0]  operand,
    input  logic [FIELD_W-1:0] field,
    output logic [PAIR_W-1:0]  result,
    output logic               last_out
);

    // Stage k conditionally shifts by 2**k; together they shift by "field".
    // The bit then sitting at position 0 is the one the final single-place
    // step pushes out, i.e. the carry for a total of field+1 places.
    logic [PAIR_W-1:0] stage [FIELD_W+1];

    assign stage[0] = operand;

    for (genvar k = 0; k < FIELD_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = field[k] ? (stage[k] >> STEP) : stage[k];
    end

    assign last_out = stage[FIELD_W][0];
    assign result   = stage[FIELD_W] >> 1;

endmodule

// File: rtl/psr_flags.sv
module psr_flags #(
    parameter int PAIR_W = 2 * psr_pkg::REG_W_DEF
) (
    input  logic [PAIR_W-1:0] result,
    input  logic              last_out,
    output psr_pkg::nzc_t     nzc
);

    always_comb begin
        nzc.n = result[PAIR_W-1];
        nzc.z = (result == '0);
        nzc.c = last_out;
    end

endmodule

// File: rtl/pair_shift_unit.sv
module pair_shift_unit #(
    parameter int REG_W   = psr_pkg::REG_W_DEF,
    parameter int WORD_W  = psr_pkg::WORD_W_DEF,
    parameter int FIELD_W = psr_pkg::FIELD_W_DEF,
    parameter int RPT_W   = psr_pkg::RPT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr_word,
    input  logic [REG_W-1:0]  acc_in,
    input  logic [REG_W-1:0]  p_in,
    input  logic [RPT_W-1:0]  rpt_count_in,
    output logic [REG_W-1:0]  acc_out,
    output logic [REG_W-1:0]  p_out,
    output logic              acc_we,
    output logic              p_we,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_we,
    output logic [RPT_W-1:0]  rpt_count_out,
    output logic              rpt_we
);
    import psr_pkg::*;

    localparam int PAIR_W = 2 * REG_W;

    logic               hit;
    logic [FIELD_W-1:0] field;
    logic [PAIR_W-1:0]  operand;
    logic [PAIR_W-1:0]  shifted;
    logic               last_out;
    nzc_t               nzc_next;
    wen_t               wen_next;

    logic [PAIR_W-1:0]  pair_q;
    nzc_t               nzc_q;
    wen_t               wen_q;
    logic [RPT_W-1:0]   rpt_q;

    assign operand = {acc_in, p_in};

    psr_decode #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_decode (
        .valid (instr_valid),
        .word  (instr_word),
        .hit   (hit),
        .field (field)
    );

    psr_shift #(.PAIR_W(PAIR_W), .FIELD_W(FIELD_W)) u_shift (
        .operand  (operand),
        .field    (field),
        .result   (shifted),
        .last_out (last_out)
    );

    psr_flags #(.PAIR_W(PAIR_W)) u_flags (
        .result   (shifted),
        .last_out (last_out),
        .nzc      (nzc_next)
    );

    always_comb begin
        wen_next       = WEN_NONE;
        wen_next.acc   = hit;
        wen_next.p     = hit;
        wen_next.flags = hit;
        wen_next.rpt   = hit && (rpt_count_in != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
            nzc_q  <= NZC_CLR;
            wen_q  <= WEN_NONE;
            rpt_q  <= '0;
        end else begin
            wen_q <= wen_next;
            if (hit) begin
                pair_q <= shifted;
                nzc_q  <= nzc_next;
                rpt_q  <= '0;
            end
        end
    end

    assign acc_out       = pair_q[PAIR_W-1:REG_W];
    assign p_out         = pair_q[REG_W-1:0];
    assign acc_we        = wen_q.acc;
    assign p_we          = wen_q.p;
    assign flag_we       = wen_q.flags;
    assign rpt_we        = wen_q.rpt;
    assign flag_n        = nzc_q.n;
    assign flag_z        = nzc_q.z;
    assign flag_c        = nzc_q.c;
    assign rpt_count_out = rpt_q;

endmodule

// File: rtl/pair_shift_unit_checker.sv
module pair_shift_unit_checker #(
    parameter int REG_W   = psr_pkg::REG_W_DEF,
    parameter int WORD_W  = psr_pkg::WORD_W_DEF,
    parameter int FIELD_W = psr_pkg::FIELD_W_DEF,
    parameter int RPT_W   = psr_pkg::RPT_W_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              instr_valid,
    input logic [WORD_W-1:0] instr_word,
    input logic [REG_W-1:0]  acc_in,
    input logic [REG_W-1:0]  p_in,
    input logic [RPT_W-1:0]  rpt_count_in,
    input logic [REG_W-1:0]  acc_out,
    input logic [REG_W-1:0]  p_out,
    input logic              acc_we,
    input logic              p_we,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_c,
    input logic              flag_we,
    input logic [RPT_W-1:0]  rpt_count_out,
    input logic              rpt_we
);
    localparam int PAIR_W = 2 * REG_W;
    localparam int TAG_W  = WORD_W - FIELD_W;

    logic              match;
    logic [PAIR_W-1:0] in_pair;
    logic [PAIR_W-1:0] out_pair;
    logic [FIELD_W:0]  amount;
    logic              bit_at_field;

    assign match        = instr_valid &&
                          (instr_word[WORD_W-1:FIELD_W] == TAG_W'(psr_pkg::OPC_TAG));
    assign in_pair      = {acc_in, p_in};
    assign out_pair     = {acc_out, p_out};
    assign amount       = {1'b0, instr_word[FIELD_W-1:0]} + 1'b1;
    assign bit_at_field = in_pair[instr_word[FIELD_W-1:0]];

    AST_EXEC_STROBE: assert property (@(posedge clk) disable iff (rst)
        match |=> (acc_we && p_we && flag_we)); // R1
    AST_SHIFT_RESULT: assert property (@(posedge clk) disable iff (rst)
        match |=> (out_pair == ($past(in_pair) >> $past(amount)))); // R2
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        acc_we |-> (acc_out[REG_W-1] == 1'b0)); // R3
    AST_CARRY_BIT: assert property (@(posedge clk) disable iff (rst)
        match |=> (flag_c == $past(bit_at_field))); // R4
    AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
        flag_we |-> (flag_n == acc_out[REG_W-1])); // R5
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        flag_we |-> (flag_z == (out_pair == '0))); // R6
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !match |=> !(acc_we || p_we || flag_we || rpt_we)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !match |=> ($stable(out_pair) && $stable({flag_n, flag_z, flag_c}))); // R7
    AST_RPT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rpt_we |-> (rpt_count_out == '0)); // R8
    AST_RPT_PENDING: assert property (@(posedge clk) disable iff (rst)
        match |=> (rpt_we == ($past(rpt_count_in) != '0))); // R8

endmodule

bind pair_shift_unit pair_shift_unit_checker #(
    .REG_W(REG_W), .WORD_W(WORD_W), .FIELD_W(FIELD_W), .RPT_W(RPT_W)
) u_checker (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .acc_in(acc_in), .p_in(p_in), .rpt_count_in(rpt_count_in),
    .acc_out(acc_out), .p_out(p_out), .acc_we(acc_we), .p_we(p_we),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_we(flag_we),
    .rpt_count_out(rpt_count_out), .rpt_we(rpt_we)
);

// File: tb/pair_shift_unit_test.sv
`timescale 1ns/1ps
module pair_shift_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [15:0] instr_word;
    logic [31:0] acc_in, p_in;
    logic [15:0] rpt_count_in;
    logic [31:0] acc_out, p_out;
    logic        acc_we, p_we, flag_n, flag_z, flag_c, flag_we, rpt_we;
    logic [15:0] rpt_count_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the held outputs.
    logic [63:0] m_pair;
    logic        m_n, m_z, m_c;
    logic [15:0] m_rpt;

    always #4 clk = ~clk;

    pair_shift_unit uut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .acc_in(acc_in), .p_in(p_in), .rpt_count_in(rpt_count_in),
        .acc_out(acc_out), .p_out(p_out), .acc_we(acc_we), .p_we(p_we),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_we(flag_we),
        .rpt_count_out(rpt_count_out), .rpt_we(rpt_we)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge: drive, wait one edge, check at next fall.
    task automatic issue(input logic v, input logic [15:0] w,
                         input logic [63:0] op, input logic [15:0] rc);
        bit          exec;
        int          amt;
        logic [63:0] res;
        instr_valid  = v;
        instr_word   = w;
        acc_in       = op[63:32];
        p_in         = op[31:0];
        rpt_count_in = rc;
        exec = v && (w[15:4] == 12'h569);
        if (exec) begin
            amt    = int'(w[3:0]) + 1;           // R2
            res    = op >> amt;                  // R3
            m_pair = res;
            m_c    = op[amt-1];                  // R4
            m_n    = res[63];                    // R5
            m_z    = (res == 64'd0);             // R6
            m_rpt  = 16'd0;
        end
        @(negedge clk);
        check(acc_we == exec && p_we == exec && flag_we == exec, "R1",
              "write enables", {61'd0, acc_we, p_we, flag_we}, {61'd0, exec, exec, exec});
        check({acc_out, p_out} == m_pair, exec ? "R3" : "R7", "register pair",
              {acc_out, p_out}, m_pair);
        check(flag_c == m_c, exec ? "R4" : "R7", "carry", 64'(flag_c), 64'(m_c));
        check(flag_n == m_n, exec ? "R5" : "R7", "negative", 64'(flag_n), 64'(m_n));
        check(flag_z == m_z, exec ? "R6" : "R7", "zero", 64'(flag_z), 64'(m_z));
        check(rpt_we == (exec && rc != 16'd0) && rpt_count_out == m_rpt, "R8",
              "repeat update", {47'd0, rpt_we, rpt_count_out},
              {47'd0, exec && rc != 16'd0, m_rpt});
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] lfsr;
        rst = 1'b1; instr_valid = 1'b0; instr_word = '0;
        acc_in = 32'hFFFF_FFFF; p_in = 32'hFFFF_FFFF; rpt_count_in = 16'hFFFF;
        m_pair = '0; m_n = 0; m_z = 0; m_c = 0; m_rpt = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check({acc_out, p_out} == 64'd0, "R9", "pair after reset", {acc_out, p_out}, 64'd0);
        check({acc_we, p_we, flag_we, rpt_we, flag_n, flag_z, flag_c} == 7'd0 &&
              rpt_count_out == 16'd0, "R9", "controls after reset",
              {41'd0, acc_we, p_we, flag_we, rpt_we, flag_n, flag_z, flag_c, rpt_count_out},
              64'd0);
        rst = 1'b0;

        // R2 R3 R4 R5: every field against single-bit, all-ones and boundary operands
        for (int f = 0; f < 16; f++) begin
            issue(1'b1, {12'h569, 4'(f)}, 64'hFFFF_FFFF_FFFF_FFFF, 16'd0);
            issue(1'b1, {12'h569, 4'(f)}, 64'd1 << f, 16'd3);          // carry only, Z set (R6)
            issue(1'b1, {12'h569, 4'(f)}, 64'd1 << (f + 1), 16'd0);     // lands at bit 0
            issue(1'b1, {12'h569, 4'(f)}, 64'h0000_0001_0000_0000, 16'd1); // crosses halves
            issue(1'b1, {12'h569, 4'(f)}, 64'h8000_0000_0000_0000, 16'd0); // top bit, zero fill
            issue(1'b0, {12'h569, 4'(f)}, 64'h1234_5678_9ABC_DEF0, 16'd7); // R7 not valid
        end
        issue(1'b1, 16'h5690, 64'd0, 16'd0); // R6 zero operand

        // R1 R7 R8: every instruction word, scrambled operands and counts
        lfsr = 64'hACE1_2468_BDF0_1357;
        for (int i = 0; i < 65536; i++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            issue(1'b1, 16'(i), lfsr, (i % 3 == 0) ? 16'd0 : lfsr[15:0] | 16'd1);
        end
        issue(1'b0, 16'h0000, 64'd0, 16'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule